// File: doc/BRIEF.md
# Floppy Sector Transfer Register File

This block is the processor-facing register set of a floppy controller. Four byte-wide registers are selected by a two-bit address: control/status, track, sector and data. A command write to the control register starts a sector read or sector write, moves the head (seek), or returns it to track zero (restore). Sector payloads of 256 bytes pass one byte per data-register access, and software paces the transfer by polling the busy and data-request bits of the status register.

The sectors themselves live in a byte-addressed buffer memory reached through a request/acknowledge storage port. On each transfer start the block computes the sector's linear byte offset from the track register, the sector register and a sectors-per-track value supplied by a configuration input. Each data-register access during a transfer then issues one storage access at that offset plus the running byte index. Reads are prefetched, so the next byte is ready in the data register before the processor asks for it. A write transfer pulses a commit strobe once the last byte has reached the buffer.

Top module: `fdc_xfer_regs`

## Requirements
- R1: The status register (address 0) reads bit 0 = busy, bit 1 = data request, bit 6 = the write_protect input, bit 7 = inverse of media_present, and all other bits 0. After reset, with media present and no write protection, it reads 0x00, the track register (address 1) reads 0 and the sector register (address 2) reads 1.
- R2: Command 0x8C or 0x9C written to address 0 sets busy and data request, resets the byte index to 0 and fetches the first byte of the sector from storage.
- R3: The storage address of byte i of a transfer is (track × sectors_per_track + sector − 1) × 256 + i, using the register values at the time the command is written.
- R4: During a read transfer, each read of the data register (address 3) returns the storage byte at the next sequential address and advances the index.
- R5: When the index reaches 256, busy and data request clear. After that, data-register reads return 0 and data-register writes issue no storage request.
- R6: Command 0xAC sets busy and data request. Each data-register write then stores its byte to storage at the next sequential address, and st_commit pulses for exactly one cycle after the 256th byte is acknowledged.
- R7: Command 0xAC written while write_protect is high starts no transfer. Status keeps busy and data request at 0, and later data writes issue no storage request.
- R8: Command 0x18 or 0x1B loads the track register with the last byte written to the data register and clears busy and data request.
- R9: Command 0x0B sets the track register to 0 and clears busy and data request.
- R10: Writing 0 to the sector register stores 1. Any other value is stored as written. The track register stores any written value.
- R11: The first status read after a transfer starts reports busy as 0 with data request 1 (0x02). Later reads report busy as 1 (0x03).
- R12: While media_present is low, a command write changes no register and starts no transfer.
- R13: Command 0xF0, and any byte that is not a listed command, changes no register and starts no transfer.
- R14: A storage request holds st_req, st_we, st_addr and st_wdata stable until st_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_addr | input | 2 | 0 control/status, 1 track, 2 sector, 3 data |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the addressed register |
| media_present | input | 1 | Medium inserted; low makes commands ignored |
| write_protect | input | 1 | Medium is write-protected |
| sec_per_trk | input | 8 | Sectors per track from configuration |
| st_req | output | 1 | Storage request |
| st_we | output | 1 | Storage request is a write |
| st_addr | output | ADDR_W | Storage byte address |
| st_wdata | output | 8 | Storage write byte |
| st_ack | input | 1 | Storage acknowledge |
| st_rdata | input | 8 | Storage read byte, valid with st_ack |
| st_commit | output | 1 | One-cycle pulse when a write sector is complete |

## Verification
Whole-sector reads and writes are run at random track, sector and sectors-per-track values. The storage model's contents are a function of the address, so any slip in the offset sum or in the byte index shows up as a wrong byte. The random sector draws include 0, which separates the forced-to-one sector rule from a plain offset bug. Directed cases cover the busy mask on the first status read, the end-of-sector cutoff for reads and writes, and seek and restore with their two opcodes. Commands issued with no medium, with write protection and with unlisted opcodes are observed at the status, track and storage ports to show that they have no effect.

// File: rtl/fdc_xfer_pkg.sv
package fdc_xfer_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_SEEK,
        OP_HOME
    } op_e;

    localparam logic [1:0] RSEL_CTL = 2'd0;
    localparam logic [1:0] RSEL_TRK = 2'd1;
    localparam logic [1:0] RSEL_SEC = 2'd2;
    localparam logic [1:0] RSEL_DAT = 2'd3;
endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode
    import fdc_xfer_pkg::*;
(
    input  logic [7:0] opcode,
    output op_e        op
);
    always_comb begin
        case (opcode)
            8'h8C, 8'h9C: op = OP_READ;
            8'hAC:        op = OP_WRITE;
            8'h18, 8'h1B: op = OP_SEEK;
            8'h0B:        op = OP_HOME;
            default:      op = OP_NONE;   // 0xF0 and unknown bytes
        endcase
    end
endmodule

// File: rtl/fdc_lba_calc.sv
module fdc_lba_calc #(
    parameter int ADDR_W     = 24,
    parameter int SECT_BYTES = 256
) (
    input  logic [7:0]        track,
    input  logic [7:0]        sector,
    input  logic [7:0]        spt,
    output logic [ADDR_W-1:0] base
);
    localparam int SHIFT = $clog2(SECT_BYTES);

    logic [ADDR_W-1:0] sect_idx;

    always_comb begin
        sect_idx = ADDR_W'(track) * ADDR_W'(spt) + ADDR_W'(sector) - ADDR_W'(1);
        base     = sect_idx << SHIFT;
    end
endmodule

// File: rtl/fdc_status_fmt.sv
module fdc_status_fmt (
    input  logic       xfer,
    input  logic       hide_busy,
    input  logic       wprot,
    input  logic       media,
    output logic [7:0] status
);
    always_comb begin
        status    = 8'h00;
        status[0] = xfer & ~hide_busy;
        status[1] = xfer;
        status[6] = wprot;
        status[7] = ~media;
    end
endmodule

// File: rtl/fdc_xfer_regs.sv
module fdc_xfer_regs
    import fdc_xfer_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int SECT_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              media_present,
    input  logic              write_protect,
    input  logic [7:0]        sec_per_trk,
    output logic              st_req,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic [7:0]        st_wdata,
    input  logic              st_ack,
    input  logic [7:0]        st_rdata,
    output logic              st_commit
);
    localparam int           CW    = $clog2(SECT_BYTES) + 1;
    localparam logic [CW-1:0] CEND = CW'(SECT_BYTES);

    typedef struct packed {
        logic [7:0]        track;
        logic [7:0]        sector;
        logic [7:0]        wbyte;
        logic [7:0]        rbyte;
        logic [CW-1:0]     count;
        logic              xfer;
        logic              hide;
        logic              is_wr;
        logic [ADDR_W-1:0] base;
        logic              req;
        logic              req_we;
        logic [ADDR_W-1:0] req_addr;
        logic [7:0]        req_wdata;
        logic              req_last;
        logic              commit;
    } state_t;

    state_t q, d;

    op_e               op;
    logic [ADDR_W-1:0] base_calc;
    logic [7:0]        status;
    logic [CW-1:0]     count_nx;

    fdc_op_decode u_dec (.opcode(cpu_wdata), .op(op));

    fdc_lba_calc #(.ADDR_W(ADDR_W), .SECT_BYTES(SECT_BYTES)) u_lba (
        .track (q.track),
        .sector(q.sector),
        .spt   (sec_per_trk),
        .base  (base_calc)
    );

    fdc_status_fmt u_stat (
        .xfer     (q.xfer),
        .hide_busy(q.hide),
        .wprot    (write_protect),
        .media    (media_present),
        .status   (status)
    );

    assign count_nx = q.count + CW'(1);

    always_comb begin
        d        = q;
        d.commit = 1'b0;

        // storage completion
        if (q.req && st_ack) begin
            d.req = 1'b0;
            if (!q.req_we)
                d.rbyte = st_rdata;
            if (q.req_we && q.req_last)
                d.commit = 1'b1;
        end

        // processor access
        if (cpu_sel) begin
            case (cpu_addr)
                RSEL_CTL: begin
                    if (!cpu_we) begin
                        d.hide = 1'b0;
                    end else if (media_present) begin
                        case (op)
                            OP_READ: begin
                                d.xfer     = 1'b1;
                                d.hide     = 1'b1;
                                d.is_wr    = 1'b0;
                                d.count    = '0;
                                d.base     = base_calc;
                                d.req      = 1'b1;
                                d.req_we   = 1'b0;
                                d.req_addr = base_calc;
                                d.req_last = 1'b0;
                            end
                            OP_WRITE: begin
                                if (!write_protect) begin
                                    d.xfer  = 1'b1;
                                    d.hide  = 1'b1;
                                    d.is_wr = 1'b1;
                                    d.count = '0;
                                    d.base  = base_calc;
                                end
                            end
                            OP_SEEK: begin
                                d.track = q.wbyte;
                                d.xfer  = 1'b0;
                                d.count = CEND;
                            end
                            OP_HOME: begin
                                d.track = 8'h00;
                                d.xfer  = 1'b0;
                                d.count = CEND;
                            end
                            default: ;
                        endcase
                    end
                end
                RSEL_TRK: begin
                    if (cpu_we)
                        d.track = cpu_wdata;
                end
                RSEL_SEC: begin
                    if (cpu_we)
                        d.sector = (cpu_wdata == 8'h00) ? 8'h01 : cpu_wdata;
                end
                default: begin
                    if (cpu_we) begin
                        d.wbyte = cpu_wdata;
                        if (q.xfer && q.is_wr) begin
                            d.req       = 1'b1;
                            d.req_we    = 1'b1;
                            d.req_addr  = q.base + ADDR_W'(q.count);
                            d.req_wdata = cpu_wdata;
                            d.req_last  = (count_nx == CEND);
                            d.count     = count_nx;
                            if (count_nx == CEND)
                                d.xfer = 1'b0;
                        end
                    end else if (q.xfer && !q.is_wr) begin
                        d.count = count_nx;
                        if (count_nx == CEND) begin
                            d.xfer = 1'b0;
                        end else begin
                            d.req      = 1'b1;
                            d.req_we   = 1'b0;
                            d.req_addr = q.base + ADDR_W'(count_nx);
                            d.req_last = 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.sector <= 8'h01;
            q.count  <= CEND;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (cpu_addr)
            RSEL_CTL: cpu_rdata = status;
            RSEL_TRK: cpu_rdata = q.track;
            RSEL_SEC: cpu_rdata = q.sector;
            default:  cpu_rdata = (q.xfer && !q.is_wr) ? q.rbyte : 8'h00;
        endcase
    end

    assign st_req    = q.req;
    assign st_we     = q.req_we;
    assign st_addr   = q.req_addr;
    assign st_wdata  = q.req_wdata;
    assign st_commit = q.commit;

    // plain views for the bound checker
    logic [7:0] trk_now;
    logic [7:0] sec_now;
    logic       xfer_now;
    assign trk_now  = q.track;
    assign sec_now  = q.sector;
    assign xfer_now = q.xfer;
endmodule

// File: rtl/fdc_xfer_chk.sv
module fdc_xfer_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_we,
    input logic [1:0]        cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              media_present,
    input logic              write_protect,
    input logic              st_req,
    input logic              st_we,
    input logic [ADDR_W-1:0] st_addr,
    input logic [7:0]        st_wdata,
    input logic              st_ack,
    input logic              st_commit,
    input logic [7:0]        trk_now,
    input logic [7:0]        sec_now,
    input logic              xfer_now
);
    logic cmd_wr;
    assign cmd_wr = cpu_sel && cpu_we && (cpu_addr == 2'd0);

    a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !st_ack |=> st_req && $stable(st_addr) && $stable(st_we) && $stable(st_wdata));

    a_r12_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !media_present |=> $stable(trk_now) && $stable(xfer_now));

    a_r7_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cpu_wdata == 8'hAC && write_protect && !xfer_now |=> !xfer_now);

    a_r9_home_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cpu_wdata == 8'h0B && media_present |=> trk_now == 8'h00 && !xfer_now);

    a_r10_sector_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        sec_now != 8'h00);

    a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_commit |=> !st_commit);

    a_r6_commit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_commit |-> $past(st_req && st_ack && st_we));
endmodule

bind fdc_xfer_regs fdc_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_sel      (cpu_sel),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .media_present(media_present),
    .write_protect(write_protect),
    .st_req       (st_req),
    .st_we        (st_we),
    .st_addr      (st_addr),
    .st_wdata     (st_wdata),
    .st_ack       (st_ack),
    .st_commit    (st_commit),
    .trk_now      (trk_now),
    .sec_now      (sec_now),
    .xfer_now     (xfer_now)
);

// File: tb/sim_fdc_xfer_regs.sv
module sim_fdc_xfer_regs;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_sel = 1'b0;
    logic              cpu_we = 1'b0;
    logic [1:0]        cpu_addr = 2'd0;
    logic [7:0]        cpu_wdata = 8'h00;
    logic [7:0]        cpu_rdata;
    logic              media_present = 1'b1;
    logic              write_protect = 1'b0;
    logic [7:0]        sec_per_trk = 8'd72;
    logic              st_req;
    logic              st_we;
    logic [ADDR_W-1:0] st_addr;
    logic [7:0]        st_wdata;
    logic              st_ack = 1'b0;
    logic [7:0]        st_rdata = 8'h00;
    logic              st_commit;

    int checks = 0;
    int errors = 0;
    int nreq = 0;
    int nwr = 0;
    int ncommit = 0;
    bit done = 1'b0;
    logic [ADDR_W-1:0] wlog_a [256];
    logic [7:0]        wlog_d [256];
    logic [7:0]        sent   [256];

    fdc_xfer_regs #(.ADDR_W(ADDR_W), .SECT_BYTES(256)) u0 (.*);

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ {a[20:16], 3'b101};
    endfunction

    function automatic logic [ADDR_W-1:0] exp_base(input int trk, input int sec, input int spt);
        int s;
        s = (sec == 0) ? 1 : sec;
        return ADDR_W'((trk * spt + s - 1) * 256);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [1:0] a, input logic [7:0] dv,
                       output logic [7:0] r);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = dv;
        #1 r = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // storage model: contents are a function of the address
    initial begin
        forever begin
            @(negedge clk);
            if (st_commit) ncommit++;
            if (st_ack) begin
                st_ack = 1'b0;
            end else if (st_req) begin
                st_ack   = 1'b1;
                st_rdata = pat(st_addr);
                if (st_we) begin
                    if (nwr < 256) begin
                        wlog_a[nwr] = st_addr;
                        wlog_d[nwr] = st_wdata;
                    end
                    nwr++;
                end
                nreq++;
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int seed;
        int bad;
        int req0;
        seed = $urandom(32'h5EED1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        acc(1'b0, 2'd0, 8'h00, r); chk("R1 reset status", r, 8'h00);
        acc(1'b0, 2'd1, 8'h00, r); chk("R1 reset track", r, 8'h00);
        acc(1'b0, 2'd2, 8'h00, r); chk("R1 reset sector", r, 8'h01);
        acc(1'b0, 2'd3, 8'h00, r); chk("R5 idle data read", r, 8'h00);

        // R1 status flag positions
        write_protect = 1'b1; media_present = 1'b0;
        acc(1'b0, 2'd0, 8'h00, r); chk("R1 wp+notready status", r, 8'hC0);
        write_protect = 1'b0; media_present = 1'b1;

        // R10 sector and track storage
        acc(1'b1, 2'd2, 8'h00, r); acc(1'b0, 2'd2, 8'h00, r); chk("R10 sector zero", r, 8'h01);
        acc(1'b1, 2'd2, 8'h07, r); acc(1'b0, 2'd2, 8'h00, r); chk("R10 sector value", r, 8'h07);
        acc(1'b1, 2'd1, 8'h33, r); acc(1'b0, 2'd1, 8'h00, r); chk("R10 track value", r, 8'h33);

        // R12 no medium: command ignored
        media_present = 1'b0;
        req0 = nreq;
        acc(1'b1, 2'd0, 8'h8C, r);
        acc(1'b1, 2'd0, 8'h0B, r);
        acc(1'b0, 2'd0, 8'h00, r); chk("R12 status no medium", r, 8'h80);
        acc(1'b0, 2'd1, 8'h00, r); chk("R12 track kept", r, 8'h33);
        chk("R12 no storage request", nreq, req0);
        media_present = 1'b1;

        // R13 no-op and unknown commands
        acc(1'b1, 2'd0, 8'hF0, r);
        acc(1'b1, 2'd0, 8'h55, r);
        acc(1'b0, 2'd0, 8'h00, r); chk("R13 status unchanged", r, 8'h00);
        acc(1'b0, 2'd1, 8'h00, r); chk("R13 track unchanged", r, 8'h33);
        chk("R13 no storage request", nreq, req0);

        // R8 seek with both opcodes
        acc(1'b1, 2'd3, 8'h2A, r); acc(1'b1, 2'd0, 8'h18, r);
        acc(1'b0, 2'd1, 8'h00, r); chk("R8 seek 0x18", r, 8'h2A);
        acc(1'b1, 2'd3, 8'h4D, r); acc(1'b1, 2'd0, 8'h1B, r);
        acc(1'b0, 2'd1, 8'h00, r); chk("R8 seek 0x1B", r, 8'h4D);
        acc(1'b0, 2'd0, 8'h00, r); chk("R8 status idle", r, 8'h00);

        // R9 restore
        acc(1'b1, 2'd0, 8'h0B, r);
        acc(1'b0, 2'd1, 8'h00, r); chk("R9 restore track", r, 8'h00);

        // R7 write-protected write
        write_protect = 1'b1;
        req0 = nreq;
        acc(1'b1, 2'd0, 8'hAC, r);
        acc(1'b0, 2'd0, 8'h00, r); chk("R7 status no busy", r, 8'h40);
        acc(1'b1, 2'd3, 8'h11, r);
        chk("R7 no storage request", nreq, req0);
        write_protect = 1'b0;

        // random sector transfers, plus a directed last-track case
        for (int it = 0; it < 8; it++) begin
            int trk, sec, spt;
            logic [ADDR_W-1:0] b;
            bit do_wr;
            if (it == 0) begin
                trk = 79; sec = 72; spt = 72; do_wr = 1'b0;
            end else if (it == 1) begin
                trk = 0; sec = 0; spt = 8; do_wr = 1'b1;
            end else begin
                spt = 8 + int'($urandom % 65);
                trk = int'($urandom % 80);
                sec = int'($urandom % (spt + 1));
                do_wr = $urandom % 2;
            end
            b = exp_base(trk, sec, spt);
            sec_per_trk = 8'(spt);
            acc(1'b1, 2'd1, 8'(trk), r);
            acc(1'b1, 2'd2, 8'(sec), r);
            nwr = 0; ncommit = 0; bad = 0;
            if (!do_wr) begin
                acc(1'b1, 2'd0, ($urandom % 2) ? 8'h8C : 8'h9C, r);
                acc(1'b0, 2'd0, 8'h00, r); chk("R11 first status masked", r, 8'h02);
                acc(1'b0, 2'd0, 8'h00, r); chk("R2 busy and request set", r, 8'h03);
                for (int i = 0; i < 256; i++) begin
                    acc(1'b0, 2'd3, 8'h00, r);
                    // R3 R4 byte i comes from base + i
                    chk("R4 read byte", r, pat(b + ADDR_W'(i)));
                end
            end else begin
                acc(1'b1, 2'd0, 8'hAC, r);
                acc(1'b0, 2'd0, 8'h00, r); chk("R11 first status masked", r, 8'h02);
                acc(1'b0, 2'd0, 8'h00, r); chk("R6 busy and request set", r, 8'h03);
                for (int i = 0; i < 256; i++) begin
                    sent[i] = 8'($urandom);
                    acc(1'b1, 2'd3, sent[i], r);
                end
                chk("R6 write count", nwr, 256);
                for (int i = 0; i < 256; i++)
                    if (wlog_a[i] !== b + ADDR_W'(i) || wlog_d[i] !== sent[i]) bad++;
                chk("R3 write addresses and data", bad, 0);
                chk("R6 single commit", ncommit, 1);
            end
            acc(1'b0, 2'd0, 8'h00, r); chk("R5 status after sector", r, 8'h00);
            acc(1'b0, 2'd3, 8'h00, r); chk("R5 read past end", r, 8'h00);
            req0 = nreq;
            acc(1'b1, 2'd3, 8'h99, r);
            chk("R5 write past end dropped", nreq, req0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule